// File: doc/BRIEF.md
# Data-Strobe Character Decoder

This block sits at the receive side of a serial link that uses data-strobe signalling. Exactly one of the two wires toggles for every bit sent, so the XOR of the two wires flips once per bit and serves as the recovered bit clock. The block samples both wires in its own clock domain. A change of that XOR marks one new bit, and the bit's value is the level of the data wire.

Bits are collected into characters after link synchronisation. Synchronisation is the first null, that is, an escape code followed by a flow-control code. Each character opens with a parity bit and a flag bit. A cleared flag means eight data bits follow, least significant first. A set flag means a two-bit control code follows, also least significant first.

Each character is classified and its parity is checked. Data bytes and packet end markers go out as 9-bit entries, with bit 8 separating data from markers. A flow-control token becomes a credit pulse. Nulls raise a sticky indication for the link start-up logic. A bad parity bit raises a sticky error and the block stops decoding until reset.

Top module: `ds_rx_decoder`

## Requirements
- R1: After reset, `rx_vld`, `fct_got`, `esc_err`, `null_seen` and `par_err` are all low.
- R2: Before the first null is recognised, incoming bits produce no entry, no credit pulse and no escape error, and `null_seen` stays low.
- R3: A null is the sequence escape (code 3) then flow-control (code 0), with valid parity. It sets `null_seen`, which stays high until reset. A null produces no entry and no credit pulse.
- R4: A character with flag 0 carries 8 data bits sent least significant first. It produces a one-cycle `rx_vld` with `rx_entry` = {1'b0, byte}.
- R5: Control code 1 (end of packet) produces `rx_entry` = 9'h100. Control code 2 (error end of packet) produces `rx_entry` = 9'h101. The two code bits are sent least significant first.
- R6: Control code 0 that does not follow an escape produces a one-cycle `fct_got` pulse.
- R7: An escape followed by any character other than flow-control produces a one-cycle `esc_err` pulse. That following character produces no entry and no credit pulse.
- R8: Parity is odd. It is counted over the previous character's payload bits plus the current parity and flag bits. On a mismatch, `par_err` goes high and stays high, and no further entry, credit pulse or escape error appears until reset.
- R9: Each change on exactly one of `ds_d`/`ds_s` is one bit, whose value is the level of `ds_d`. Decoding does not depend on the bit period as long as it is at least 2 clock cycles.
- R10: `rx_vld`, `fct_got` and `esc_err` are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ds_d | input | 1 | Data wire |
| ds_s | input | 1 | Strobe wire |
| rx_vld | output | 1 | Entry valid pulse |
| rx_entry | output | 9 | Bit 8: end marker; bits 7:0: data byte or marker kind |
| fct_got | output | 1 | Flow-control credit pulse |
| null_seen | output | 1 | Sticky: a null has been recognised |
| par_err | output | 1 | Sticky parity error; decoding halted |
| esc_err | output | 1 | Pulse: escape followed by a non-flow-control character |

## Verification
The assertions assume that the two wires never toggle together. They also assume a bit period of at least two sampling clocks, so every XOR change is seen once. The bench encoder moves exactly one wire per bit and holds each bit for 2 to 5 clocks.

Some checks rely on the character stream itself. The junk sent before synchronisation is chosen so that it cannot contain the null bit pattern. After synchronisation, parity is generated correctly, except for the one corrupted character that tests the halt on parity error.

// File: rtl/ds_rx_pkg.sv
package ds_rx_pkg;
  localparam int DATA_W  = 8;
  localparam int CTL_W   = 2;
  localparam int ENTRY_W = DATA_W + 1;
  localparam int IDX_W   = 4;

  typedef enum logic [CTL_W-1:0] {
    CTL_FCT = 2'd0,
    CTL_EOP = 2'd1,
    CTL_EEP = 2'd2,
    CTL_ESC = 2'd3
  } ctl_code_e;

  typedef struct packed {
    logic              par;
    logic              flag;
    logic [DATA_W-1:0] body;
  } ds_char_t;

  // index of the last bit of a character (parity is index 0)
  function automatic logic [IDX_W-1:0] char_last(input logic flag);
    return flag ? IDX_W'(CTL_W + 1) : IDX_W'(DATA_W + 1);
  endfunction

  // odd parity over previous payload, current parity and flag
  function automatic logic parity_good(input logic prev_x, input logic par,
                                       input logic flag);
    return prev_x ^ par ^ flag;
  endfunction

  function automatic logic [ENTRY_W-1:0] marker_entry(input ctl_code_e code);
    return {1'b1, {(DATA_W-1){1'b0}}, (code == CTL_EEP)};
  endfunction
endpackage

// File: rtl/ds_bit_recover.sv
module ds_bit_recover #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ds_d,
  input  logic ds_s,
  output logic bit_vld,
  output logic bit_val
);
  logic [SYNC_STAGES-1:0] d_sync, s_sync;
  logic d_now, s_now, d_prev, s_prev;
  logic rclk, rclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_sync <= '0;
      s_sync <= '0;
      d_prev <= 1'b0;
      s_prev <= 1'b0;
      rclk_prev <= 1'b0;
    end else begin
      d_sync <= {d_sync[SYNC_STAGES-2:0], ds_d};
      s_sync <= {s_sync[SYNC_STAGES-2:0], ds_s};
      d_prev <= d_now;
      s_prev <= s_now;
      rclk_prev <= rclk;
    end
  end

  assign d_now   = d_sync[SYNC_STAGES-1];
  assign s_now   = s_sync[SYNC_STAGES-1];
  assign rclk    = d_now ^ s_now;
  assign bit_vld = rclk ^ rclk_prev;
  assign bit_val = d_now;

  // R9: input assumption, never both wires in one sample step
  p_one_wire_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({d_now ^ d_prev, s_now ^ s_prev}) <= 1)
    else $error("both data and strobe changed together");
endmodule

// File: rtl/ds_char_framer.sv
module ds_char_framer
  import ds_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bit_vld,
  input  logic     bit_val,
  output logic     char_vld,
  output ds_char_t char_q,
  output logic     sync_hit
);
  // oldest first: flag,esc0,esc1,par,flag,fct0,fct1
  localparam logic [6:0] NULL_PAT = 7'b1110100;

  typedef enum logic {ST_HUNT, ST_RUN} fr_st_e;
  fr_st_e            st;
  logic [5:0]        hunt_sh;
  logic [IDX_W-1:0]  idx, pos;
  logic              par_r, flag_r;
  logic [DATA_W-1:0] body_r, body_n;
  logic              last_bit, null_match;

  assign null_match = (st == ST_HUNT) && bit_vld && ({hunt_sh, bit_val} == NULL_PAT);

  always_comb begin
    pos    = idx - IDX_W'(2);
    body_n = body_r;
    if (idx >= IDX_W'(2)) body_n[pos[2:0]] = bit_val;
    last_bit = (idx >= IDX_W'(2)) && (idx == char_last(flag_r));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_HUNT;
      hunt_sh <= '0;
      idx <= '0;
      par_r <= 1'b0;
      flag_r <= 1'b0;
      body_r <= '0;
      char_vld <= 1'b0;
      char_q <= '0;
      sync_hit <= 1'b0;
    end else begin
      char_vld <= 1'b0;
      sync_hit <= 1'b0;
      if (st == ST_HUNT) begin
        if (bit_vld) hunt_sh <= {hunt_sh[4:0], bit_val};
        if (null_match) begin
          st <= ST_RUN;
          idx <= '0;
          sync_hit <= 1'b1;
        end
      end else if (bit_vld) begin
        if (idx == IDX_W'(0)) begin
          par_r  <= bit_val;
          body_r <= '0;
          idx    <= IDX_W'(1);
        end else if (idx == IDX_W'(1)) begin
          flag_r <= bit_val;
          idx    <= IDX_W'(2);
        end else begin
          body_r <= body_n;
          if (last_bit) begin
            char_vld <= 1'b1;
            char_q   <= '{par: par_r, flag: flag_r, body: body_n};
            idx      <= '0;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
      end
    end
  end

  // R2: nothing framed while still hunting for the first null
  p_quiet_in_hunt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HUNT) |-> !char_vld)
    else $error("character framed before sync");
  // R5: control characters carry only the low code bits
  p_ctl_body_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (char_vld && char_q.flag) |-> (char_q.body[DATA_W-1:CTL_W] == '0))
    else $error("control character with stray payload bits");
endmodule

// File: rtl/ds_char_classify.sv
module ds_char_classify
  import ds_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               char_vld,
  input  ds_char_t           char_q,
  input  logic               sync_hit,
  output logic               rx_vld,
  output logic [ENTRY_W-1:0] rx_entry,
  output logic               fct_got,
  output logic               null_seen,
  output logic               par_err,
  output logic               esc_err
);
  logic      prev_x, esc_pend;
  logic      take, parity_bad;
  ctl_code_e code;

  assign take       = char_vld && !par_err;
  assign parity_bad = take && !parity_good(prev_x, char_q.par, char_q.flag);
  assign code       = ctl_code_e'(char_q.body[CTL_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_x <= 1'b0;
      esc_pend <= 1'b0;
      null_seen <= 1'b0;
      par_err <= 1'b0;
      rx_vld <= 1'b0;
      rx_entry <= '0;
      fct_got <= 1'b0;
      esc_err <= 1'b0;
    end else begin
      rx_vld  <= 1'b0;
      fct_got <= 1'b0;
      esc_err <= 1'b0;
      if (sync_hit) begin
        null_seen <= 1'b1;
        prev_x    <= 1'b0;
        esc_pend  <= 1'b0;
      end else if (parity_bad) begin
        par_err <= 1'b1;
      end else if (take) begin
        prev_x <= ^char_q.body;
        if (esc_pend) begin
          esc_pend <= 1'b0;
          if (char_q.flag && code == CTL_FCT) null_seen <= 1'b1;
          else esc_err <= 1'b1;
        end else if (!char_q.flag) begin
          rx_vld   <= 1'b1;
          rx_entry <= {1'b0, char_q.body};
        end else begin
          case (code)
            CTL_FCT: fct_got  <= 1'b1;
            CTL_ESC: esc_pend <= 1'b1;
            default: begin
              rx_vld   <= 1'b1;
              rx_entry <= marker_entry(code);
            end
          endcase
        end
      end
    end
  end

  // R10: one event per cycle
  p_one_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_vld, fct_got, esc_err}))
    else $error("more than one event in a cycle");
  // R6: credit is a single-cycle pulse
  p_fct_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fct_got |=> !fct_got)
    else $error("credit pulse longer than one cycle");
  // R8: parity error is sticky and silences the outputs
  p_par_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> par_err)
    else $error("parity error cleared");
  p_par_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(par_err) |-> !(rx_vld || fct_got || esc_err))
    else $error("event after parity error");
  // R3: null indication is sticky
  p_null_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    null_seen |=> null_seen)
    else $error("null indication dropped");
  // R5: marker entries only carry the kind bit
  p_marker_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && rx_entry[ENTRY_W-1]) |-> (rx_entry[DATA_W-1:1] == '0))
    else $error("malformed end marker");
endmodule

// File: rtl/ds_rx_decoder.sv
module ds_rx_decoder
  import ds_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ds_d,
  input  logic               ds_s,
  output logic               rx_vld,
  output logic [ENTRY_W-1:0] rx_entry,
  output logic               fct_got,
  output logic               null_seen,
  output logic               par_err,
  output logic               esc_err
);
  logic     bit_vld, bit_val;
  logic     char_vld, sync_hit;
  ds_char_t char_q;

  ds_bit_recover #(.SYNC_STAGES(SYNC_STAGES)) u_bits (
    .clk(clk), .rst_n(rst_n), .ds_d(ds_d), .ds_s(ds_s),
    .bit_vld(bit_vld), .bit_val(bit_val)
  );

  ds_char_framer u_frame (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .char_vld(char_vld), .char_q(char_q), .sync_hit(sync_hit)
  );

  ds_char_classify u_class (
    .clk(clk), .rst_n(rst_n), .char_vld(char_vld), .char_q(char_q),
    .sync_hit(sync_hit), .rx_vld(rx_vld), .rx_entry(rx_entry),
    .fct_got(fct_got), .null_seen(null_seen), .par_err(par_err),
    .esc_err(esc_err)
  );

  // R1: quiet outputs in the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !(rx_vld || fct_got || esc_err || par_err))
    else $error("output active right after reset");
endmodule

// File: tb/ds_rx_decoder_tb.sv
module ds_rx_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, ds_d = 1'b0, ds_s = 1'b0;
  logic rx_vld, fct_got, null_seen, par_err, esc_err;
  logic [8:0] rx_entry;

  always #(CLK_PERIOD/2) clk = ~clk;

  ds_rx_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .ds_d(ds_d), .ds_s(ds_s),
    .rx_vld(rx_vld), .rx_entry(rx_entry), .fct_got(fct_got),
    .null_seen(null_seen), .par_err(par_err), .esc_err(esc_err)
  );

  typedef struct { int kind; int val; string tag; } exp_t;
  localparam int K_DATA = 1, K_FCT = 2, K_ESC = 3;
  exp_t exp_q[$];
  int total = 0, bad = 0;
  int per = 3;
  bit prevx = 0, m_sync = 0, m_esc = 0, m_perr = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push(input int k, input int v, input string tag);
    exp_t e;
    e.kind = k; e.val = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      int k;
      int cnt;
      cnt = int'(rx_vld) + int'(fct_got) + int'(esc_err);
      if (cnt > 1) check(0, "R10 events per cycle", cnt, 1);
      k = rx_vld ? K_DATA : fct_got ? K_FCT : esc_err ? K_ESC : 0;
      if (k != 0) begin
        if (exp_q.size() == 0) begin
          check(0, "R2/R8 unexpected event kind", k, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.kind == k && (k != K_DATA || e.val == int'(rx_entry)),
                e.tag, k * 65536 + int'(rx_entry), e.kind * 65536 + e.val);
        end
      end
    end
  end

  task automatic send_bit(input bit b);
    @(posedge clk); #1;
    if (b == ds_d) ds_s = ~ds_s; else ds_d = b;
    repeat (per - 1) @(posedge clk);
  endtask

  // raw character on the wire; bad flips the parity bit
  task automatic wire_char(input bit flag, input logic [7:0] body, input bit corrupt);
    bit p;
    int n;
    p = ~(prevx ^ flag) ^ corrupt;
    n = flag ? 2 : 8;
    send_bit(p);
    send_bit(flag);
    for (int i = 0; i < n; i++) send_bit(body[i]);
    prevx = flag ? ^body[1:0] : ^body;
  endtask

  task automatic send_data(input logic [7:0] b);
    if (m_sync && !m_perr) begin
      if (m_esc) begin push(K_ESC, 0, "R7 esc then data"); m_esc = 0; end
      else push(K_DATA, {24'd0, 1'b0, b}, "R4 data entry");
    end
    wire_char(1'b0, b, 1'b0);
  endtask

  task automatic send_ctl(input logic [1:0] c);
    if (m_sync && !m_perr) begin
      if (m_esc) begin
        if (c != 2'd0) push(K_ESC, 0, "R7 esc then non-fct");
        m_esc = 0;
      end else begin
        case (c)
          2'd0: push(K_FCT, 0, "R6 credit pulse");
          2'd1: push(K_DATA, 'h100, "R5 end of packet");
          2'd2: push(K_DATA, 'h101, "R5 error end of packet");
          default: m_esc = 1;
        endcase
      end
    end
    wire_char(1'b1, {6'd0, c}, 1'b0);
  endtask

  task automatic send_null();
    if (!m_sync) begin
      wire_char(1'b1, 8'd3, 1'b0);
      wire_char(1'b1, 8'd0, 1'b0);
      m_sync = 1; m_esc = 0;
    end else begin
      send_ctl(2'd3);
      send_ctl(2'd0);
    end
  endtask

  task automatic drain(input string tag);
    repeat (12) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check({rx_vld, fct_got, esc_err, null_seen, par_err} == 5'b0, "R1 reset outputs",
          {rx_vld, fct_got, esc_err, null_seen, par_err}, 0);

    // R2: junk before sync (contains no null pattern)
    send_ctl(2'd0); send_data(8'h0F); send_ctl(2'd0); send_ctl(2'd1);
    drain("R2 no events before sync");
    check(null_seen == 1'b0, "R2 null_seen before sync", null_seen, 0);

    // R3: first null
    send_null();
    drain("R3 null gives no event");
    check(null_seen == 1'b1, "R3 null_seen after null", null_seen, 1);

    // R4, R9 at several bit periods
    per = 2; send_data(8'hA5); send_data(8'h00);
    per = 5; send_data(8'hFF); send_data(8'h3C);
    per = 3; send_data(8'h81);
    drain("R9 data at varied bit periods");

    // R5, R6
    send_ctl(2'd0); send_ctl(2'd1); send_ctl(2'd2); send_ctl(2'd0);
    drain("R5 markers and R6 credits");

    // R7
    send_ctl(2'd3); send_ctl(2'd1);
    send_ctl(2'd3); send_data(8'h55);
    send_ctl(2'd3); send_ctl(2'd3);
    send_data(8'h12);
    drain("R7 escape errors");

    // R3 later null, sticky
    send_null(); send_data(8'h77);
    drain("R3 later null");
    check(null_seen == 1'b1, "R3 null_seen sticky", null_seen, 1);

    // R8 parity error then silence
    check(par_err == 1'b0, "R8 no parity error yet", par_err, 0);
    wire_char(1'b0, 8'h42, 1'b1);
    m_perr = 1;
    send_data(8'h99); send_ctl(2'd0); send_ctl(2'd1);
    drain("R8 halted after parity error");
    check(par_err == 1'b1, "R8 parity error raised", par_err, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule